// File: doc/BRIEF.md
# Mipmap Texel Address Generator

This block turns a per-pixel texture coordinate pair and a level-of-detail into a linear texture-memory address. Texture memory holds a whole mipmap pyramid with its levels packed one after another from a programmable base. The largest stored level (level 1) is 512 x 512 texels, and each further level halves the side. Every clock the block samples the two 10-bit coordinates, a 4-bit level, a level-source select bit and a user-supplied level. One clock later it presents the 20-bit address on a registered output.

No multiplier and no wide coordinate adder are used. The row term is made by shifting t left by ten minus the level. The column coordinate s is dropped into the low bits that this shift leaves empty, by a per-bit select. The start of each level is a constant bit pattern decoded from the level. Only one adder chain remains, and it sums the merged word, the base and the level start.

Top module: `texaddr_gen`

## Requirements
- R1: s_in, t_in, lod_in, lod_src_sel and user_lod are sampled on a rising clock edge, and the address built from them appears on tex_addr after the next rising edge. The output register changes on no other edge.
- R2: When lod_src_sel is 0 the level used is user_lod. When it is 1 the level used is lod_in. Both are taken from the same sampling edge.
- R3: The level start for level q is (q-1) copies of the bit pair "01" placed from bit 19 downward (bit 19 = 0, bit 18 = 1, and so on), with zeros below. Levels 0 and 1 give 0. Any level of 10 or more gives nine copies, so its low two bits are 00.
- R4: t is shifted left by 10 minus the level for levels 1 to 10. Level 0 shifts by 10, and levels 11 to 15 shift by 0.
- R5: Bit i of the low 10 bits takes s[i] when i is below the shift amount, and takes the shifted t otherwise. Bits of s at or above the shift amount have no effect on tex_addr.
- R6: tex_addr equals (merged word + base + level start) modulo 2^20. For in-range coordinates this is base + start(l) + t*2^(10-l) + s.
- R7: A base write (base_wr_en = 1) loads base_wr_data on a rising edge, and the new base shows on tex_addr one edge later. While base_wr_en is 0 the base does not change, whatever base_wr_data carries.
- R8: Synchronous active-high reset clears the base, the sampled inputs and tex_addr to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| s_in | input | 10 | Column texture coordinate |
| t_in | input | 10 | Row texture coordinate |
| lod_in | input | 4 | Per-pixel level-of-detail |
| lod_src_sel | input | 1 | 1 selects lod_in, 0 selects user_lod |
| user_lod | input | 4 | Fixed level used when mipmapping is off |
| base_wr_en | input | 1 | Base address write strobe |
| base_wr_data | input | 20 | Base address value to load |
| tex_addr | output | 20 | Registered texel address |

## Verification
A wrong level decode moves tex_addr by a whole level region, often hundreds of thousands of words. A wrong shift or a wrong select mask corrupts the row or column bits. Either fault shows on the output register one edge after the faulty pixel is sampled. A base register that drifts or ignores its strobe moves every later address by the same amount, starting one edge after the bad write. For this reason the checks look at both the pixel patterns and the timing of base writes against held inputs.

// File: rtl/texaddr_pkg.sv
package texaddr_pkg;

    localparam int COORD_W = 10;
    localparam int LVL_W   = 4;
    localparam int ADDR_W  = 2 * COORD_W;
    localparam int SHAMT_W = $clog2(COORD_W + 1);
    localparam int PAIRS   = COORD_W - 1;

    typedef struct packed {
        logic [COORD_W-1:0] s;
        logic [COORD_W-1:0] t;
        logic [LVL_W-1:0]   lvl;
    } texel_req_t;

    // Row shift for a level: level 0 and levels above COORD_W are special cases
    function automatic logic [SHAMT_W-1:0] level_shift(input logic [LVL_W-1:0] lvl);
        if (lvl == '0)
            return SHAMT_W'(COORD_W);
        else if (int'(lvl) <= COORD_W)
            return SHAMT_W'(COORD_W - int'(lvl));
        else
            return '0;
    endfunction

    // Bits below the shift amount are column bits
    function automatic logic [COORD_W-1:0] column_mask(input logic [SHAMT_W-1:0] shamt);
        logic [COORD_W-1:0] m;
        for (int i = 0; i < COORD_W; i++)
            m[i] = (int'(shamt) > i);
        return m;
    endfunction

endpackage

// File: rtl/texaddr_capture.sv
module texaddr_capture
    import texaddr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [COORD_W-1:0] s_in,
    input  logic [COORD_W-1:0] t_in,
    input  logic [LVL_W-1:0]   lod_in,
    input  logic               lod_src_sel,
    input  logic [LVL_W-1:0]   user_lod,
    output texel_req_t         req
);

    logic [COORD_W-1:0] s_q, t_q;
    logic [LVL_W-1:0]   lod_q, ulod_q;
    logic               sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q    <= '0;
            t_q    <= '0;
            lod_q  <= '0;
            ulod_q <= '0;
            sel_q  <= 1'b0;
        end else begin
            s_q    <= s_in;
            t_q    <= t_in;
            lod_q  <= lod_in;
            ulod_q <= user_lod;
            sel_q  <= lod_src_sel;
        end
    end

    always_comb begin
        req.s   = s_q;
        req.t   = t_q;
        req.lvl = sel_q ? lod_q : ulod_q;
    end

endmodule

// File: rtl/texaddr_offset.sv
module texaddr_offset
    import texaddr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LVL_W-1:0]  lvl,
    output logic [ADDR_W-1:0] level_start
);

    localparam int PAD_W = ADDR_W - 2 * PAIRS;

    genvar k;
    generate
        for (k = 0; k < PAIRS; k++) begin : g_pair
            assign level_start[ADDR_W-1-2*k] = 1'b0;
            assign level_start[ADDR_W-2-2*k] = (int'(lvl) > k + 1);
        end
        if (PAD_W > 0) begin : g_pad
            assign level_start[PAD_W-1:0] = '0;
        end
    endgenerate

    AST_START_LOW_LEVELS: assert property (@(posedge clk) disable iff (rst)
        (lvl <= LVL_W'(1)) |-> (level_start == '0));                              // R3
    AST_START_EVEN_BITS: assert property (@(posedge clk) disable iff (rst)
        (level_start & {COORD_W{2'b10}}) == '0);                                  // R3

endmodule

// File: rtl/texaddr_shifter.sv
module texaddr_shifter
    import texaddr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [COORD_W-1:0] din,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [ADDR_W-1:0]  dout
);

    logic [ADDR_W-1:0] stage [SHAMT_W+1];

    assign stage[0] = ADDR_W'(din);

    genvar i;
    generate
        for (i = 0; i < SHAMT_W; i++) begin : g_stage
            assign stage[i+1] = shamt[i] ? (stage[i] << (1 << i)) : stage[i];
        end
    endgenerate

    assign dout = stage[SHAMT_W];

    AST_SHIFT_REVERSIBLE: assert property (@(posedge clk) disable iff (rst)
        (int'(shamt) <= COORD_W) |-> ((dout >> shamt) == ADDR_W'(din)));          // R4

endmodule

// File: rtl/texaddr_gen.sv
module texaddr_gen
    import texaddr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [COORD_W-1:0] s_in,
    input  logic [COORD_W-1:0] t_in,
    input  logic [LVL_W-1:0]   lod_in,
    input  logic               lod_src_sel,
    input  logic [LVL_W-1:0]   user_lod,
    input  logic               base_wr_en,
    input  logic [ADDR_W-1:0]  base_wr_data,
    output logic [ADDR_W-1:0]  tex_addr
);

    texel_req_t         req;
    logic [SHAMT_W-1:0] shamt;
    logic [COORD_W-1:0] col_mask;
    logic [ADDR_W-1:0]  row_word;
    logic [ADDR_W-1:0]  level_start;
    logic [ADDR_W-1:0]  merged;
    logic [ADDR_W-1:0]  base_q;
    logic [ADDR_W-1:0]  addr_q;

    texaddr_capture u_capture (
        .clk(clk), .rst(rst), .s_in(s_in), .t_in(t_in), .lod_in(lod_in),
        .lod_src_sel(lod_src_sel), .user_lod(user_lod), .req(req)
    );

    assign shamt    = level_shift(req.lvl);
    assign col_mask = column_mask(shamt);

    texaddr_shifter u_shifter (
        .clk(clk), .rst(rst), .din(req.t), .shamt(shamt), .dout(row_word)
    );

    texaddr_offset u_offset (
        .clk(clk), .rst(rst), .lvl(req.lvl), .level_start(level_start)
    );

    genvar b;
    generate
        for (b = 0; b < COORD_W; b++) begin : g_merge
            assign merged[b] = col_mask[b] ? req.s[b] : row_word[b];
        end
    endgenerate
    assign merged[ADDR_W-1:COORD_W] = row_word[ADDR_W-1:COORD_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            addr_q <= '0;
        end else begin
            if (base_wr_en)
                base_q <= base_wr_data;
            addr_q <= merged + base_q + level_start;
        end
    end

    assign tex_addr = addr_q;

    AST_BASE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !base_wr_en |=> $stable(base_q));                                         // R7
    AST_ADDR_TRACKS_STATE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(req) && $stable(base_q)) |=> $stable(addr_q));    // R1
    AST_ROW_BITS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (row_word[COORD_W-1:0] & col_mask) == '0);                                // R5

endmodule

// File: tb/texaddr_gen_tb.sv
`timescale 1ns/1ps
module texaddr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [9:0]  s_in, t_in;
    logic [3:0]  lod_in, user_lod;
    logic        lod_src_sel;
    logic        base_wr_en;
    logic [19:0] base_wr_data;
    logic [19:0] tex_addr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    texaddr_gen dut_i (
        .clk(clk), .rst(rst), .s_in(s_in), .t_in(t_in), .lod_in(lod_in),
        .lod_src_sel(lod_src_sel), .user_lod(user_lod),
        .base_wr_en(base_wr_en), .base_wr_data(base_wr_data), .tex_addr(tex_addr)
    );

    localparam int NV = 8;
    localparam int VS   [NV] = '{5,    100,     5,     1, 0,       1023, 0,  0};
    localparam int VT   [NV] = '{3,    200,     6,     1, 0,       1023, 1,  0};
    localparam int VLOD [NV] = '{0,    3,       7,     9, 10,      0,    2,  12};
    localparam int VSEL [NV] = '{1,    1,       0,     1, 1,       1,    0,  1};
    localparam int VUL  [NV] = '{7,    0,       7,     0, 0,       0,    4,  0};
    localparam int VB   [NV] = '{0, 'h12345, 'h00100,  0, 'hFFFFF, 1,    9,  7};

    // Reference built from the requirements
    function automatic int model(int s, int t, int lvl, int base);
        int sh, q, off, merged;
        sh  = (lvl == 0) ? 10 : ((lvl <= 10) ? 10 - lvl : 0);
        q   = (lvl > 10) ? 10 : lvl;
        off = 0;
        for (int i = 1; i < q; i++) off += (1 << (2 * (10 - i)));
        merged = (t << sh) | (s & ((1 << sh) - 1));
        return (merged + base + off) & 'hFFFFF;
    endfunction

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%05h expected=%05h", req, actual, expected);
        end
    endtask

    task automatic drive(int s, int t, int lod, int sel, int ulod);
        s_in = 10'(s); t_in = 10'(t); lod_in = 4'(lod);
        lod_src_sel = sel[0]; user_lod = 4'(ulod);
    endtask

    task automatic write_base(int b);
        @(negedge clk);
        base_wr_en = 1'b1; base_wr_data = 20'(b);
        @(negedge clk);
        base_wr_en = 1'b0; base_wr_data = 20'h0;
    endtask

    // Apply at a falling edge, wait two rising edges, sample at the falling edge
    task automatic run_pixel(int s, int t, int lod, int sel, int ulod);
        @(negedge clk);
        drive(s, t, lod, sel, ulod);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int prev;
        rst = 1'b1; base_wr_en = 1'b0; base_wr_data = '0;
        drive(0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R8 reset output", int'(tex_addr), 0);

        // Vector table: R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            write_base(VB[v]);
            run_pixel(VS[v], VT[v], VLOD[v], VSEL[v], VUL[v]);
            check($sformatf("R6 vector %0d", v), int'(tex_addr),
                  model(VS[v], VT[v], (VSEL[v] != 0) ? VLOD[v] : VUL[v], VB[v]));
        end

        // R3 R5: level 8, s out of range, hand value 0x55540 + (5<<2 | 3)
        write_base(0);
        run_pixel('h3FF, 5, 8, 1, 0);
        check("R5 high s bits ignored", int'(tex_addr), 'h55557);

        // R3: level 15 equals level 10 start, shift 0
        run_pixel(0, 3, 15, 1, 0);
        check("R3 R4 level above ten", int'(tex_addr), 'h55554 + 3);

        // R2: same inputs, select toggled
        run_pixel(2, 7, 2, 1, 5);
        check("R2 select incoming level", int'(tex_addr), model(2, 7, 2, 0));
        run_pixel(2, 7, 2, 0, 5);
        check("R2 select user level", int'(tex_addr), model(2, 7, 5, 0));

        // R1: latency of two edges
        run_pixel(1, 1, 9, 1, 0);
        prev = int'(tex_addr);
        @(negedge clk);
        drive(0, 2, 9, 1, 0);
        @(posedge clk);
        @(negedge clk);
        check("R1 output holds one edge", int'(tex_addr), prev);
        @(posedge clk);
        @(negedge clk);
        check("R1 output after two edges", int'(tex_addr), model(0, 2, 9, 0));

        // R7: base write timing and hold
        prev = int'(tex_addr);
        @(negedge clk);
        base_wr_en = 1'b1; base_wr_data = 20'h00400;
        @(posedge clk);
        @(negedge clk);
        base_wr_en = 1'b0; base_wr_data = 20'hABCDE;
        check("R7 base not yet visible", int'(tex_addr), prev);
        @(posedge clk);
        @(negedge clk);
        check("R7 base visible", int'(tex_addr), model(0, 2, 9, 'h400));
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R7 data ignored without strobe", int'(tex_addr), model(0, 2, 9, 'h400));

        // R8: reset in mid run clears base and output
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R8 output cleared", int'(tex_addr), 0);
        rst = 1'b0;
        run_pixel(0, 0, 0, 1, 0);
        check("R8 base cleared", int'(tex_addr), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule